// File: doc/BRIEF.md
# Burst-of-two DDR SRAM protocol core

This core models the command and data behaviour of a pipelined double-data-rate static RAM in which every access moves two words. On each rising clock edge it samples an active-low load strobe, a read/write select and a word address. A write command is followed one cycle later by two write beats, each with its own active-low byte-lane enables. A read command returns two beats one cycle later, together with an output-enable for the shared data bus. Both beats are presented side by side on the single internal clock. A small register-based storage array holds the data.

Sampling a command moves the bus-cycle state machine into one of three states for the following cycle: `ST_NOP` (no command), `ST_READ` or `ST_WRITE`. Each state can move to any of the three. A low load strobe with `rw` high leads to `ST_READ`, a low strobe with `rw` low leads to `ST_WRITE`, and a high strobe leads to `ST_NOP`. In `ST_WRITE` the two beats are captured into a posted-write register, which is committed to the array on the following edge. In `ST_READ` the two words are read from the array and merged lane by lane with any posted write to the same words, and the result is registered onto the outputs. Commands may follow each other on consecutive cycles with no idle cycle between them.

Top module: `burst2_sram_core`

## Requirements
- R1: A command is taken only when `load_n` is low at a rising edge. With `load_n` high the cycle is a no-operation: `addr`, `rw` and the write data and enables of the next cycle leave the storage unchanged.
- R2: With `load_n` low, `rw`=1 requests a read and `rw`=0 requests a write. Beat 0 uses the start address A and beat 1 uses A with bit 0 inverted.
- R3: Write beats are sampled at the rising edge that ends the cycle after the write command. `wdata0` is stored at A and `wdata1` at A with bit 0 inverted.
- R4: Byte lane i is bits [9i+8:9i] and is enabled by bit i of `wen0_n` (beat 0) or `wen1_n` (beat 1). The enable is active low. A lane whose enable is 1 keeps its stored value.
- R5: For a read command sampled at edge t, `rdata0`/`rdata1` carry beat 0 and beat 1 and `dq_oe` is 1 after edge t+1. The read data registers keep their value in cycles that do not follow a read.
- R6: After a no-operation or write cycle, `dq_oe` is 0 one cycle later. Reset clears `dq_oe`, `rdata0`, `rdata1` and every storage word to zero.
- R7: A read issued directly after a write returns the just-written beats for any overlapping word, without waiting for the array. Lanes that were masked in that write come from the stored contents.
- R8: Reads and writes may be issued on consecutive cycles in any mix, and every burst completes intact.
- R9: With `NARROW`=1, bit 0 of the start address is forced to 0, so both beats always go to the even/odd word pair in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 = read, 0 = write, when `load_n` is low |
| addr | input | ADDR_W | Word start address of the burst |
| wdata0 | input | LANES*LANE_W | First write beat, given in the cycle after a write command |
| wdata1 | input | LANES*LANE_W | Second write beat, same cycle as `wdata0` |
| wen0_n | input | LANES | Active-low lane enables for beat 0 |
| wen1_n | input | LANES | Active-low lane enables for beat 1 |
| rdata0 | output | LANES*LANE_W | First read beat |
| rdata1 | output | LANES*LANE_W | Second read beat |
| dq_oe | output | 1 | Data-bus output enable, high while read beats are driven |

## Verification
The hardest situation to reach is a read that lands exactly one cycle after a write to the same word pair. It has to be checked with the start address both equal and bit-0-swapped, and with lanes partly masked, because only then does the posted-write merge decide the result. The vector table places such read-after-write pairs directly after writes with mixed masks. A random phase then confines most addresses to eight words, so that these overlaps recur under random masks and back-to-back command mixes. A second instance built with `NARROW`=1 receives the same stimulus and is checked against its own model, in which the start address is forced even.

// File: rtl/burst2_pkg.sv
`timescale 1ns/1ps
package burst2_pkg;

    typedef enum logic [1:0] {
        ST_NOP   = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

    // Decode of the sampled command pins into the next bus-cycle state.
    function automatic bus_state_e decode_cmd(input logic load_n, input logic rw);
        if (load_n)
            return ST_NOP;
        else if (rw)
            return ST_READ;
        else
            return ST_WRITE;
    endfunction

endpackage

// File: rtl/burst2_cmd_fsm.sv
`timescale 1ns/1ps
module burst2_cmd_fsm
    import burst2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter bit NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output bus_state_e        state,
    output logic [ADDR_W-1:0] base_addr,
    output logic              wr_capture,
    output logic              rd_launch
);

    bus_state_e        nxt_state;
    logic [ADDR_W-1:0] start_addr;

    generate
        if (NARROW) begin : g_narrow
            assign start_addr = {addr[ADDR_W-1:1], 1'b0};
        end else begin : g_full
            assign start_addr = addr;
        end
    endgenerate

    // Next-state logic
    always_comb begin
        nxt_state = ST_NOP;
        unique case (state)
            ST_NOP:   nxt_state = decode_cmd(load_n, rw);
            ST_READ:  nxt_state = decode_cmd(load_n, rw);
            ST_WRITE: nxt_state = decode_cmd(load_n, rw);
            default:  nxt_state = ST_NOP;
        endcase
    end

    // State register and command address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_NOP;
            base_addr <= '0;
        end else begin
            state <= nxt_state;
            if (!load_n)
                base_addr <= start_addr;
        end
    end

    // Outputs per state
    always_comb begin
        wr_capture = 1'b0;
        rd_launch  = 1'b0;
        unique case (state)
            ST_NOP:   ;
            ST_READ:  rd_launch  = 1'b1;
            ST_WRITE: wr_capture = 1'b1;
            default:  ;
        endcase
    end

    // R1: a no-operation cycle leaves the captured address untouched
    assert_nop_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(base_addr));

    generate
        if (NARROW) begin : g_narrow_chk
            // R9: narrow variant always starts on an even word
            assert_narrow_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (state != ST_NOP) |-> (base_addr[0] == 1'b0));
        end
    endgenerate

endmodule

// File: rtl/burst2_array.sv
`timescale 1ns/1ps
module burst2_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [ADDR_W-1:0]       wbase,
    input  logic [LANES*LANE_W-1:0] wd0,
    input  logic [LANES*LANE_W-1:0] wd1,
    input  logic [LANES-1:0]        wm0_n,
    input  logic [LANES-1:0]        wm1_n,
    input  logic [ADDR_W-1:0]       rbase,
    output logic [LANES*LANE_W-1:0] rq0,
    output logic [LANES*LANE_W-1:0] rq1
);

    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0]     mem [DEPTH];
    logic [ADDR_W-1:0] wpart;
    logic [ADDR_W-1:0] rpart;

    assign wpart = {wbase[ADDR_W-1:1], ~wbase[0]};
    assign rpart = {rbase[ADDR_W-1:1], ~rbase[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++)
                mem[w] <= '0;
        end else if (commit) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wm0_n[l])
                    mem[wbase][l*LANE_W +: LANE_W] <= wd0[l*LANE_W +: LANE_W];
                if (!wm1_n[l])
                    mem[wpart][l*LANE_W +: LANE_W] <= wd1[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rq0 = mem[rbase];
    assign rq1 = mem[rpart];

endmodule

// File: rtl/burst2_wr_post.sv
`timescale 1ns/1ps
module burst2_wr_post #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [ADDR_W-1:0]       cbase,
    input  logic [LANES*LANE_W-1:0] wd0,
    input  logic [LANES*LANE_W-1:0] wd1,
    input  logic [LANES-1:0]        wm0_n,
    input  logic [LANES-1:0]        wm1_n,
    input  logic [ADDR_W-1:0]       rbase,
    input  logic [LANES*LANE_W-1:0] aq0,
    input  logic [LANES*LANE_W-1:0] aq1,
    output logic                    commit,
    output logic [ADDR_W-1:0]       pbase,
    output logic [LANES*LANE_W-1:0] pd0,
    output logic [LANES*LANE_W-1:0] pd1,
    output logic [LANES-1:0]        pm0_n,
    output logic [LANES-1:0]        pm1_n,
    output logic [LANES*LANE_W-1:0] fq0,
    output logic [LANES*LANE_W-1:0] fq1
);

    logic hit_same;
    logic hit_swap;

    // Posted write: beats held for one cycle, then committed to the array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit <= 1'b0;
            pbase  <= '0;
            pd0    <= '0;
            pd1    <= '0;
            pm0_n  <= '1;
            pm1_n  <= '1;
        end else begin
            commit <= capture;
            if (capture) begin
                pbase <= cbase;
                pd0   <= wd0;
                pd1   <= wd1;
                pm0_n <= wm0_n;
                pm1_n <= wm1_n;
            end
        end
    end

    assign hit_same = commit && (rbase == pbase);
    assign hit_swap = commit && (rbase == {pbase[ADDR_W-1:1], ~pbase[0]});

    // Lane-wise merge of the posted write over the array words
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_comb begin
                fq0[l*LANE_W +: LANE_W] = aq0[l*LANE_W +: LANE_W];
                fq1[l*LANE_W +: LANE_W] = aq1[l*LANE_W +: LANE_W];
                if (hit_same) begin
                    if (!pm0_n[l]) fq0[l*LANE_W +: LANE_W] = pd0[l*LANE_W +: LANE_W];
                    if (!pm1_n[l]) fq1[l*LANE_W +: LANE_W] = pd1[l*LANE_W +: LANE_W];
                end else if (hit_swap) begin
                    if (!pm1_n[l]) fq0[l*LANE_W +: LANE_W] = pd1[l*LANE_W +: LANE_W];
                    if (!pm0_n[l]) fq1[l*LANE_W +: LANE_W] = pd0[l*LANE_W +: LANE_W];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/burst2_sram_core.sv
`timescale 1ns/1ps
module burst2_sram_core
    import burst2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter bit NARROW = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_n,
    input  logic                    rw,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata0,
    input  logic [LANES*LANE_W-1:0] wdata1,
    input  logic [LANES-1:0]        wen0_n,
    input  logic [LANES-1:0]        wen1_n,
    output logic [LANES*LANE_W-1:0] rdata0,
    output logic [LANES*LANE_W-1:0] rdata1,
    output logic                    dq_oe
);

    localparam int DW = LANES * LANE_W;

    bus_state_e        state;
    logic [ADDR_W-1:0] base_addr;
    logic              wr_capture;
    logic              rd_launch;
    logic              commit;
    logic [ADDR_W-1:0] pbase;
    logic [DW-1:0]     pd0, pd1;
    logic [LANES-1:0]  pm0_n, pm1_n;
    logic [DW-1:0]     aq0, aq1;
    logic [DW-1:0]     fq0, fq1;

    burst2_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .NARROW (NARROW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .rw         (rw),
        .addr       (addr),
        .state      (state),
        .base_addr  (base_addr),
        .wr_capture (wr_capture),
        .rd_launch  (rd_launch)
    );

    burst2_wr_post #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (wr_capture),
        .cbase   (base_addr),
        .wd0     (wdata0),
        .wd1     (wdata1),
        .wm0_n   (wen0_n),
        .wm1_n   (wen1_n),
        .rbase   (base_addr),
        .aq0     (aq0),
        .aq1     (aq1),
        .commit  (commit),
        .pbase   (pbase),
        .pd0     (pd0),
        .pd1     (pd1),
        .pm0_n   (pm0_n),
        .pm1_n   (pm1_n),
        .fq0     (fq0),
        .fq1     (fq1)
    );

    burst2_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .wbase  (pbase),
        .wd0    (pd0),
        .wd1    (pd1),
        .wm0_n  (pm0_n),
        .wm1_n  (pm1_n),
        .rbase  (base_addr),
        .rq0    (aq0),
        .rq1    (aq1)
    );

    // Output register: read beats and bus enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            rdata0 <= '0;
            rdata1 <= '0;
        end else begin
            dq_oe <= rd_launch;
            if (rd_launch) begin
                rdata0 <= fq0;
                rdata1 <= fq1;
            end
        end
    end

    // R5: a read command is followed two edges later by an enabled bus
    assert_read_drives_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(!load_n && rw, 2)) |-> dq_oe);

    // R6: a no-operation or write cycle releases the bus
    assert_nop_releases_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(load_n || !rw, 2)) |-> !dq_oe);

    // R5: read beats change only after a read command
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(!load_n && rw, 2)) |-> ($stable(rdata0) && $stable(rdata1)));

endmodule

// File: tb/test_burst2_sram_core.sv
`timescale 1ns/1ps
module test_burst2_sram_core;

    localparam int    AW     = 6;
    localparam int    LN     = 2;
    localparam int    LW     = 9;
    localparam int    DW     = LN * LW;
    localparam int    DEPTH  = 1 << AW;
    localparam real   CLK_NS = 4.0;

    typedef struct packed {
        logic [1:0]    kind;   // 0 nop, 1 read, 2 write
        logic [AW-1:0] a;
        logic [LN-1:0] m0;
        logic [LN-1:0] m1;
        logic [7:0]    seed;
    } vec_t;

    localparam vec_t TABLE [17] = '{
        '{2'd1, 6'd30, 2'b00, 2'b00, 8'h00},
        '{2'd2, 6'd4,  2'b00, 2'b00, 8'h11},
        '{2'd0, 6'd0,  2'b00, 2'b00, 8'h00},
        '{2'd1, 6'd4,  2'b00, 2'b00, 8'h00},
        '{2'd1, 6'd5,  2'b00, 2'b00, 8'h00},
        '{2'd2, 6'd9,  2'b00, 2'b00, 8'h22},
        '{2'd1, 6'd9,  2'b00, 2'b00, 8'h00},
        '{2'd1, 6'd8,  2'b00, 2'b00, 8'h00},
        '{2'd2, 6'd8,  2'b01, 2'b10, 8'h33},
        '{2'd1, 6'd8,  2'b00, 2'b00, 8'h00},
        '{2'd2, 6'd20, 2'b00, 2'b00, 8'h44},
        '{2'd1, 6'd21, 2'b00, 2'b00, 8'h00},
        '{2'd2, 6'd21, 2'b11, 2'b11, 8'h55},
        '{2'd1, 6'd21, 2'b00, 2'b00, 8'h00},
        '{2'd0, 6'd21, 2'b00, 2'b00, 8'h00},
        '{2'd1, 6'd20, 2'b00, 2'b00, 8'h00},
        '{2'd0, 6'd0,  2'b00, 2'b00, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_n;
    logic          rw;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata0, wdata1;
    logic [LN-1:0] wen0_n, wen1_n;
    logic [DW-1:0] rdata0, rdata1, n_rdata0, n_rdata1;
    logic          dq_oe, n_dq_oe;

    logic [DW-1:0] mem_w [DEPTH];
    logic [DW-1:0] mem_n [DEPTH];

    int checks = 0;
    int fails  = 0;

    logic [1:0]    prev_kind = 2'd0, prev2_kind = 2'd0;
    logic [AW-1:0] prev_addr = '0;
    logic [LN-1:0] prev_m0 = '0, prev_m1 = '0;
    logic [7:0]    prev_seed = '0;
    logic          pend_rd = 1'b0, pend_fwd = 1'b0;
    logic [DW-1:0] pend_w0, pend_w1, pend_n0, pend_n1;
    string         tag_now = "reset";

    always #(CLK_NS / 2.0) clk = ~clk;

    burst2_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .NARROW(1'b0)) i_burst2_sram_core (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .rw(rw), .addr(addr),
        .wdata0(wdata0), .wdata1(wdata1), .wen0_n(wen0_n), .wen1_n(wen1_n),
        .rdata0(rdata0), .rdata1(rdata1), .dq_oe(dq_oe));

    burst2_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .NARROW(1'b1)) i_burst2_sram_core_narrow (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .rw(rw), .addr(addr),
        .wdata0(wdata0), .wdata1(wdata1), .wen0_n(wen0_n), .wen1_n(wen1_n),
        .rdata0(n_rdata0), .rdata1(n_rdata1), .dq_oe(n_dq_oe));

    task automatic check_word(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mkd(input logic [7:0] seed, input logic beat);
        logic [7:0] hi;
        logic [9:0] lo;
        hi = seed ^ (beat ? 8'hA5 : 8'h3C);
        lo = {1'b0, seed, beat} + 10'd77;
        return {hi, lo};
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                               input logic [LN-1:0] m0, input logic [LN-1:0] m1);
        logic [AW-1:0] an;
        an = {a[AW-1:1], 1'b0};
        for (int l = 0; l < LN; l++) begin
            if (!m0[l]) mem_w[a][l*LW +: LW] = d0[l*LW +: LW];
            if (!m1[l]) mem_w[a ^ 6'd1][l*LW +: LW] = d1[l*LW +: LW];
            if (!m0[l]) mem_n[an][l*LW +: LW] = d0[l*LW +: LW];
            if (!m1[l]) mem_n[an | 6'd1][l*LW +: LW] = d1[l*LW +: LW];
        end
    endtask

    task automatic step(input logic [1:0] kind, input logic [AW-1:0] a, input logic [LN-1:0] m0,
                        input logic [LN-1:0] m1, input logic [7:0] seed);
        string dtag;
        logic [AW-1:0] an;
        @(negedge clk);
        // 1: outputs of the read issued two cycles ago
        checks++;
        if (dq_oe !== pend_rd) begin
            fails++;
            $display("FAIL %s R5 R6 dq_oe act=%b exp=%b", tag_now, dq_oe, pend_rd);
        end
        checks++;
        if (n_dq_oe !== pend_rd) begin
            fails++;
            $display("FAIL %s R5 R6 narrow dq_oe act=%b exp=%b", tag_now, n_dq_oe, pend_rd);
        end
        if (pend_rd) begin
            dtag = pend_fwd ? "R7 forwarded beat" : "R2 R3 R4 burst beat";
            check_word({tag_now, " ", dtag, "0"}, rdata0, pend_w0);
            check_word({tag_now, " ", dtag, "1"}, rdata1, pend_w1);
            check_word({tag_now, " R9 narrow beat0"}, n_rdata0, pend_n0);
            check_word({tag_now, " R9 narrow beat1"}, n_rdata1, pend_n1);
        end
        // 2: expectation for the command issued last cycle
        pend_rd  = (prev_kind == 2'd1);
        pend_fwd = (prev2_kind == 2'd2);
        if (pend_rd) begin
            an      = {prev_addr[AW-1:1], 1'b0};
            pend_w0 = mem_w[prev_addr];
            pend_w1 = mem_w[prev_addr ^ 6'd1];
            pend_n0 = mem_n[an];
            pend_n1 = mem_n[an | 6'd1];
        end
        // 3: write beats for the command issued last cycle, else junk
        if (prev_kind == 2'd2) begin
            wdata0 = mkd(prev_seed, 1'b0);
            wdata1 = mkd(prev_seed, 1'b1);
            wen0_n = prev_m0;
            wen1_n = prev_m1;
            model_write(prev_addr, wdata0, wdata1, prev_m0, prev_m1);
        end else begin
            wdata0 = DW'($urandom);
            wdata1 = DW'($urandom);
            wen0_n = '0;
            wen1_n = '0;
        end
        // 4: new command
        load_n     = (kind == 2'd0);
        rw         = (kind == 2'd1);
        addr       = a;
        prev2_kind = prev_kind;
        prev_kind  = kind;
        prev_addr  = a;
        prev_m0    = m0;
        prev_m1    = m1;
        prev_seed  = seed;
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        fails++;
        $display("FAIL R8 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < DEPTH; w++) begin
            mem_w[w] = '0;
            mem_n[w] = '0;
        end
        rst_n  = 1'b0;
        load_n = 1'b0;
        rw     = 1'b1;
        addr   = 6'd3;
        wdata0 = '1;
        wdata1 = '1;
        wen0_n = '0;
        wen1_n = '0;
        repeat (3) @(negedge clk);
        // R6: reset state
        check_word("R6 reset dq_oe", {17'd0, dq_oe}, '0);
        check_word("R6 reset rdata0", rdata0, '0);
        check_word("R6 reset rdata1", rdata1, '0);
        check_word("R6 reset narrow dq_oe", {17'd0, n_dq_oe}, '0);
        load_n = 1'b1;
        rw     = 1'b0;
        rst_n  = 1'b1;

        tag_now = "table";
        for (int i = 0; i < 17; i++)
            step(TABLE[i].kind, TABLE[i].a, TABLE[i].m0, TABLE[i].m1, TABLE[i].seed);

        // R1: no-operation cycles with live address, rw and data are ignored
        tag_now = "R1 nop ignored";
        step(2'd0, 6'd4, 2'b00, 2'b00, 8'h99);
        step(2'd0, 6'd5, 2'b00, 2'b00, 8'h98);
        step(2'd0, 6'd20, 2'b00, 2'b00, 8'h97);
        step(2'd1, 6'd4, 2'b00, 2'b00, 8'h00);
        step(2'd1, 6'd20, 2'b00, 2'b00, 8'h00);
        step(2'd0, 6'd0, 2'b00, 2'b00, 8'h00);

        // R8: back-to-back mixes with no idle cycle
        tag_now = "R8 back-to-back";
        step(2'd2, 6'd12, 2'b00, 2'b00, 8'h61);
        step(2'd1, 6'd13, 2'b00, 2'b00, 8'h00);
        step(2'd2, 6'd13, 2'b10, 2'b01, 8'h62);
        step(2'd2, 6'd12, 2'b01, 2'b00, 8'h63);
        step(2'd1, 6'd12, 2'b00, 2'b00, 8'h00);
        step(2'd1, 6'd13, 2'b00, 2'b00, 8'h00);
        step(2'd2, 6'd40, 2'b00, 2'b00, 8'h64);
        step(2'd1, 6'd12, 2'b00, 2'b00, 8'h00);
        step(2'd1, 6'd41, 2'b00, 2'b00, 8'h00);
        step(2'd0, 6'd0, 2'b00, 2'b00, 8'h00);

        // Random mixes, mostly on eight words so overlaps recur
        tag_now = "random R4 R7 R8";
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] ra;
            ra = (i % 4 == 0) ? AW'($urandom) : AW'($urandom_range(7, 0));
            step(2'($urandom_range(2, 0)), ra, LN'($urandom), LN'($urandom), 8'($urandom));
        end

        tag_now = "flush";
        repeat (3) step(2'd0, 6'd0, 2'b00, 2'b00, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule